// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Transmitter

This block is the sending half of a buffered synchronous serial port. A host places a word into a holding register split into a low half and a high half. Writing the low half marks the word as pending. Whenever the shift stage is not sending a frame, the whole holding register is copied into a 32-bit shift register. The block then waits for a frame-sync pulse and sends the word on a single data line, one bit per transmit-clock tick, most significant bit first.

A transmit-clock tick is a one-cycle enable pulse, `bit_tick`, in the system clock domain. A programmable data delay of 0, 1 or 2 ticks separates the frame-sync sample from the first data bit. A ready flag tells the host when the holding register can take the next word. A sticky underflow flag records a frame sync that arrived when no new word had been loaded since the previous frame.

Top module: `fs_word_tx`

## Requirements
- R1: A `wr_lo` pulse clears `tx_ready`, which reads 0 in the cycle that follows the write.
- R2: A pending word is copied into the shift register one cycle after the write, and `tx_ready` returns to 1. The copy is not made while a frame is in progress or in the cycle a frame starts, so `tx_ready` stays 0 until the frame has ended.
- R3: With a word length of 16 or fewer bits, only the low half is sent, and the content of the high half has no effect on the line.
- R4: With a word length above 16 bits, the high half supplies the upper bits: bit i of the sent word, for i >= 16, is bit i-16 of the high half.
- R5: A low-half write that is not preceded by a high-half write sends the high-half value held from before.
- R6: Nothing is sent until `fsync` is high on a cycle with `bit_tick` while no frame is in progress. `ser_out` is 0 whenever no data bit is being driven.
- R7: `dly_sel` sets the data delay: 0 puts the first bit on the line at the tick that samples frame sync, 1 puts it one tick later, and 2 or 3 put it two ticks later.
- R8: `len_sel` sets the word length: 0 is 8 bits, 1 is 12, 2 is 16, 3 is 20, 4 is 24, and 5 to 7 are 32. The bits are sent most significant first, one per tick, and exactly that many bits are sent before the line returns to 0.
- R9: `fsync` is ignored while a frame is in progress, whether the frame is in its delay or in its data bits.
- R10: A frame sync that finds no word loaded since the previous frame sends the old shift-register contents again and sets `underflow`. The flag stays set until a `clr_underflow` pulse clears it. If a set and a clear fall in the same cycle, the set takes effect.
- R11: After reset, `tx_ready` is 1, `ser_out` is 0 and `underflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe for the low half; this write marks a word as pending |
| wr_hi | input | 1 | Write strobe for the high half |
| wr_data | input | 16 | Data for either half |
| len_sel | input | 3 | Word-length select |
| dly_sel | input | 2 | Data-delay select |
| bit_tick | input | 1 | Transmit-clock rising-edge enable |
| fsync | input | 1 | Frame sync, sampled on `bit_tick` |
| clr_underflow | input | 1 | Clears the underflow flag |
| ser_out | output | 1 | Serial data line |
| tx_ready | output | 1 | High when the holding register can take a new word |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach from the ports is a low-half write that lands while a frame is still shifting. The holding register must then keep the word, and the shift register must keep sending the old one until the last bit is out. The stimulus starts a frame, stops after a few ticks, performs a full write while the sequencer is still in its data phase, and then resumes ticking. A reference model runs alongside and follows the deferred copy cycle by cycle. The same bench triggers a frame with nothing loaded to reach the retransmit path, and raises frame sync in the middle of a frame.

// File: rtl/fs_word_tx_pkg.sv
package fs_word_tx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_SHIFT = 2'd2
  } seq_state_e;

  // Delay select 3 behaves as 2.
  function automatic logic [1:0] dly_decode(input logic [1:0] sel);
    return (sel == 2'd3) ? 2'd2 : sel;
  endfunction

  // Word length minus one for each length code.
  function automatic int unsigned len_top(input logic [2:0] sel);
    case (sel)
      3'd0:    return 7;
      3'd1:    return 11;
      3'd2:    return 15;
      3'd3:    return 19;
      3'd4:    return 23;
      default: return 31;
    endcase
  endfunction

endpackage

// File: rtl/fs_word_tx_rst_sync.sv
module fs_word_tx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_sync = s1_q;
endmodule

// File: rtl/fs_word_tx_hold.sv
module fs_word_tx_hold #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              load_ok,
  output logic              xfer,
  output logic [WORD_W-1:0] word,
  output logic              tx_ready
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic              pend_q, pend_d;
  logic              pend_en;

  // Next-state: the copy consumes the pending word; a fresh write re-arms it.
  always_comb begin
    xfer    = pend_q & load_ok;
    pend_d  = pend_q;
    if (xfer)  pend_d = 1'b0;
    if (wr_lo) pend_d = 1'b1;
    pend_en = xfer | wr_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_lo)   lo_q   <= wr_data;
      if (wr_hi)   hi_q   <= wr_data;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign word     = {hi_q, lo_q};
  assign tx_ready = ~pend_q;
endmodule

// File: rtl/fs_word_tx_seq.sv
module fs_word_tx_seq
  import fs_word_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             fsync,
  input  logic [2:0]       len_sel,
  input  logic [1:0]       dly_sel,
  input  logic             xfer,
  input  logic             clr_underflow,
  output logic             load_ok,
  output logic             busy,
  output logic             drv_en,
  output logic             drv_clr,
  output logic [PTR_W-1:0] drv_idx,
  output logic             underflow
);
  seq_state_e       state_q, state_d;
  logic [1:0]       dcnt_q, dcnt_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             fresh_q, fresh_d;
  logic             uflow_q, uflow_d;
  logic             start;
  logic [PTR_W-1:0] top_idx;
  logic [1:0]       dly;

  always_comb begin
    if (len_top(len_sel) > WORD_W - 1) top_idx = PTR_W'(WORD_W - 1);
    else                               top_idx = PTR_W'(len_top(len_sel));
    dly = dly_decode(dly_sel);
  end

  assign start   = (state_q == SEQ_IDLE) & bit_tick & fsync;
  assign load_ok = (state_q == SEQ_IDLE) & ~start;
  assign busy    = (state_q != SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    ptr_d   = ptr_q;
    drv_en  = 1'b0;
    drv_clr = 1'b0;
    drv_idx = ptr_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          ptr_d = top_idx;
          if (dly == 2'd0) begin
            drv_en  = 1'b1;
            drv_idx = top_idx;
            state_d = SEQ_SHIFT;
          end else begin
            dcnt_d  = dly;
            state_d = SEQ_DELAY;
          end
        end
      end
      SEQ_DELAY: begin
        if (bit_tick) begin
          if (dcnt_q == 2'd1) begin
            drv_en  = 1'b1;
            drv_idx = ptr_q;
            state_d = SEQ_SHIFT;
          end else begin
            dcnt_d = dcnt_q - 2'd1;
          end
        end
      end
      SEQ_SHIFT: begin
        if (bit_tick) begin
          if (ptr_q == '0) begin
            drv_clr = 1'b1;
            state_d = SEQ_IDLE;
          end else begin
            ptr_d   = ptr_q - 1'b1;
            drv_en  = 1'b1;
            drv_idx = ptr_q - 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // Fresh marks a loaded word not yet sent; a set of the flag beats a clear.
  always_comb begin
    fresh_d = fresh_q;
    if (start) fresh_d = 1'b0;
    if (xfer)  fresh_d = 1'b1;
    uflow_d = uflow_q;
    if (clr_underflow)      uflow_d = 1'b0;
    if (start && !fresh_q)  uflow_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      dcnt_q  <= '0;
      ptr_q   <= '0;
      fresh_q <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start || bit_tick) begin
        dcnt_q <= dcnt_d;
        ptr_q  <= ptr_d;
      end
      if (start || xfer)                fresh_q <= fresh_d;
      if (start || clr_underflow)       uflow_q <= uflow_d;
    end
  end

  assign underflow = uflow_q;
endmodule

// File: rtl/fs_word_tx_out.sv
module fs_word_tx_out #(
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              drv_en,
  input  logic              drv_clr,
  input  logic [PTR_W-1:0]  drv_idx,
  output logic              ser_out
);
  logic [WORD_W-1:0] xsr_q;
  logic              out_q, out_d, out_en;

  always_comb begin
    out_en = drv_en | drv_clr;
    out_d  = drv_clr ? 1'b0 : xsr_q[drv_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xsr_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (load)   xsr_q <= word;
      if (out_en) out_q <= out_d;
    end
  end

  assign ser_out = out_q;
endmodule

// File: rtl/fs_word_tx.sv
module fs_word_tx #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PTR_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [2:0]        len_sel,
  input  logic [1:0]        dly_sel,
  input  logic              bit_tick,
  input  logic              fsync,
  input  logic              clr_underflow,
  output logic              ser_out,
  output logic              tx_ready,
  output logic              underflow
);
  logic              rst_n_i;
  logic              xfer, load_ok, seq_busy;
  logic              drv_en, drv_clr;
  logic [PTR_W-1:0]  drv_idx;
  logic [WORD_W-1:0] word;

  fs_word_tx_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  fs_word_tx_hold #(.HALF_W(HALF_W)) u_hold (
    .clk(clk), .rst_n(rst_n_i), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .load_ok(load_ok), .xfer(xfer),
    .word(word), .tx_ready(tx_ready)
  );

  fs_word_tx_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n_i), .bit_tick(bit_tick), .fsync(fsync),
    .len_sel(len_sel), .dly_sel(dly_sel), .xfer(xfer),
    .clr_underflow(clr_underflow), .load_ok(load_ok), .busy(seq_busy),
    .drv_en(drv_en), .drv_clr(drv_clr), .drv_idx(drv_idx),
    .underflow(underflow)
  );

  fs_word_tx_out #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n_i), .load(xfer), .word(word),
    .drv_en(drv_en), .drv_clr(drv_clr), .drv_idx(drv_idx),
    .ser_out(ser_out)
  );
endmodule

// File: rtl/fs_word_tx_chk.sv
module fs_word_tx_chk (
  input logic clk,
  input logic rst_n_i,
  input logic wr_lo,
  input logic tx_ready,
  input logic underflow,
  input logic clr_underflow,
  input logic ser_out,
  input logic seq_busy,
  input logic xfer,
  input logic bit_tick,
  input logic fsync
);
  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_lo |=> !tx_ready); // R1

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    xfer |-> !seq_busy); // R2

  AST_READY_RESTORES: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!tx_ready && !seq_busy && !(bit_tick && fsync) && !wr_lo) |=> tx_ready); // R2

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_i)
    !seq_busy |-> !ser_out); // R6

  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n_i)
    (underflow && !clr_underflow) |=> underflow); // R10

  AST_UFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_i)
    (underflow && clr_underflow && seq_busy) |=> !underflow); // R10
endmodule

bind fs_word_tx fs_word_tx_chk u_chk (
  .clk(clk), .rst_n_i(rst_n_i), .wr_lo(wr_lo), .tx_ready(tx_ready),
  .underflow(underflow), .clr_underflow(clr_underflow), .ser_out(ser_out),
  .seq_busy(seq_busy), .xfer(xfer), .bit_tick(bit_tick), .fsync(fsync)
);

// File: tb/fs_word_tx_test.sv
module fs_word_tx_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_lo, wr_hi, bit_tick, fsync, clr_underflow;
  logic [15:0] wr_data;
  logic [2:0]  len_sel;
  logic [1:0]  dly_sel;
  logic        ser_out, tx_ready, underflow;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fs_word_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .len_sel(len_sel), .dly_sel(dly_sel),
    .bit_tick(bit_tick), .fsync(fsync), .clr_underflow(clr_underflow),
    .ser_out(ser_out), .tx_ready(tx_ready), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_lo, m_hi;
  logic [31:0] m_sr;
  int  m_mode, m_wait, m_ptr, m_d;
  bit  m_pend, m_fresh, m_uf, m_out, m_ufset;

  function automatic int len_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;   3'd1: return 12;  3'd2: return 16;
      3'd3: return 20;  3'd4: return 24;  default: return 32;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_sr = 0; m_mode = 0; m_wait = 0; m_ptr = 0;
      m_pend = 0; m_fresh = 0; m_uf = 0; m_out = 0;
    end else begin
      m_ufset = 0;
      if (m_mode == 0) begin
        if (bit_tick && fsync) begin
          if (m_fresh) m_fresh = 0; else m_ufset = 1;
          m_ptr = len_of(len_sel) - 1;
          m_d = (dly_sel == 2'd3) ? 2 : int'(dly_sel);
          if (m_d == 0) begin m_out = m_sr[m_ptr]; m_mode = 2; end
          else begin m_wait = m_d; m_mode = 1; end
        end else if (m_pend) begin
          m_sr = {m_hi, m_lo}; m_fresh = 1; m_pend = 0;
        end
      end else if (m_mode == 1) begin
        if (bit_tick) begin
          m_wait--;
          if (m_wait == 0) begin m_out = m_sr[m_ptr]; m_mode = 2; end
        end
      end else begin
        if (bit_tick) begin
          if (m_ptr == 0) begin m_out = 0; m_mode = 0; end
          else begin m_ptr--; m_out = m_sr[m_ptr]; end
        end
      end
      if (m_ufset) m_uf = 1; else if (clr_underflow) m_uf = 0;
      if (wr_hi) m_hi = wr_data;
      if (wr_lo) begin m_lo = wr_data; m_pend = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ser_out == m_out, "R8", "model ser_out", 32'(ser_out), 32'(m_out));
      chk(tx_ready == !m_pend, "R2", "model tx_ready", 32'(tx_ready), 32'(!m_pend));
      chk(underflow == m_uf, "R10", "model underflow", 32'(underflow), 32'(m_uf));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic write_word(input logic [15:0] hi, input logic [15:0] lo, input bit do_hi);
    @(posedge clk); #2;
    if (do_hi) begin wr_hi = 1; wr_data = hi; end
    @(posedge clk); #2;
    wr_hi = 0; wr_lo = 1; wr_data = lo;
    @(posedge clk); #2;
    wr_lo = 0;
    @(negedge clk);
    chk(tx_ready == 0, "R1", "ready after low write", 32'(tx_ready), 0);
  endtask

  task automatic tick(input bit fs, output bit s);
    @(posedge clk); #2;
    bit_tick = 1; fsync = fs;
    @(posedge clk); #2;
    bit_tick = 0; fsync = 0;
    @(negedge clk);
    s = ser_out;
  endtask

  task automatic frame(input logic [31:0] exp, input int nbits, input int dly,
                       input string req, input bit fs_mid);
    bit s;
    logic [31:0] got = 0;
    logic [31:0] mask = (nbits == 32) ? 32'hFFFF_FFFF : ((32'd1 << nbits) - 1);
    for (int t = 0; t <= dly + nbits; t++) begin
      tick((t == 0) || (fs_mid && t == dly + 2), s);
      if (t < dly)
        chk(s == 0, "R7", "line during delay", 32'(s), 0);
      else if (t < dly + nbits)
        got = {got[30:0], s};
      else
        chk(s == 0, "R8", "line after last bit", 32'(s), 0);
    end
    chk(got == (exp & mask), req, "received word", got, exp & mask);
  endtask

  task automatic wait_ready;
    @(negedge clk);
    chk(tx_ready == 1, "R2", "ready after copy", 32'(tx_ready), 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL R6 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    bit s;
    rst_n = 0; wr_lo = 0; wr_hi = 0; wr_data = 0; bit_tick = 0; fsync = 0;
    clr_underflow = 0; len_sel = 0; dly_sel = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tx_ready == 1, "R11", "reset ready", 32'(tx_ready), 1);
    chk(ser_out == 0, "R11", "reset line", 32'(ser_out), 0);
    chk(underflow == 0, "R11", "reset underflow", 32'(underflow), 0);

    for (int i = 0; i < 3; i++) begin
      tick(0, s);
      chk(s == 0, "R6", "no frame sync, line quiet", 32'(s), 0);
    end

    // 8-bit word, delay 1
    len_sel = 3'd0; dly_sel = 2'd1;
    write_word(16'hFFFF, 16'h12A5, 1); wait_ready();
    frame(32'hA5, 8, 1, "R8", 0);

    // 16-bit word, high half must not matter, delay 0
    len_sel = 3'd2; dly_sel = 2'd0;
    write_word(16'hBEEF, 16'h8001, 1); wait_ready();
    frame(32'h8001, 16, 0, "R3", 0);

    // 20-bit word, delay 2
    len_sel = 3'd3; dly_sel = 2'd2;
    write_word(16'h0005, 16'h1234, 1); wait_ready();
    frame(32'h51234, 20, 2, "R4", 0);

    // 32-bit word, delay 1
    len_sel = 3'd5; dly_sel = 2'd1;
    write_word(16'hCAFE, 16'h0F0F, 1); wait_ready();
    frame(32'hCAFE0F0F, 32, 1, "R4", 0);

    // 24-bit word with stale high half
    len_sel = 3'd4; dly_sel = 2'd0;
    write_word(16'h0000, 16'h7777, 0); wait_ready();
    frame(32'hFE7777, 24, 0, "R5", 0);

    // 12-bit word, delay code 3, frame sync mid-frame
    len_sel = 3'd1; dly_sel = 2'd3;
    write_word(16'h0000, 16'h0ABC, 0); wait_ready();
    frame(32'hABC, 12, 2, "R7", 1);
    chk(underflow == 0, "R9", "mid-frame sync no underflow", 32'(underflow), 0);
    tick(0, s);
    chk(s == 0, "R9", "no second frame started", 32'(s), 0);

    // underflow: frame with nothing new loaded
    len_sel = 3'd1; dly_sel = 2'd0;
    frame(32'hABC, 12, 0, "R10", 0);
    chk(underflow == 1, "R10", "underflow set", 32'(underflow), 1);
    @(posedge clk); #2 clr_underflow = 1;
    @(posedge clk); #2 clr_underflow = 0;
    @(negedge clk);
    chk(underflow == 0, "R10", "underflow cleared", 32'(underflow), 0);

    // write during an active frame: copy must wait
    len_sel = 3'd0; dly_sel = 2'd0;
    write_word(16'h0000, 16'h003C, 0); wait_ready();
    tick(1, s); tick(0, s); tick(0, s);
    write_word(16'h0000, 16'h005A, 0);
    @(negedge clk);
    chk(tx_ready == 0, "R2", "copy held while busy", 32'(tx_ready), 0);
    for (int i = 0; i < 6; i++) tick(0, s);
    @(negedge clk); @(negedge clk);
    chk(tx_ready == 1, "R2", "copy after frame end", 32'(tx_ready), 1);
    frame(32'h5A, 8, 0, "R8", 0);
    chk(underflow == 0, "R10", "fresh word no underflow", 32'(underflow), 0);

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule